// File: doc/BRIEF.md
# Ring Slot Node with Self-Discovery

This block is one sensor node on a circular serial chain. A host sends a frame of fixed-size slots around the ring, and the frame passes through every node before it returns to the host. Each node reads the frame serially, keeps every foreign slot intact, and in the one slot it owns it captures the incoming word and puts its own transmit word in its place.

A node starts out without a slot. While it has none, it looks in each frame for the first slot that holds nothing but zeros and writes a claim word carrying its non-zero address into it. A node further down the ring then sees that slot as non-zero, treats it as taken and moves on to the next empty one. The claimed slot index is then held until reset. Each slot is 48 bits wide: a 16-bit header followed by a 32-bit data field, sent most significant bit first. The node holds one full slot in flight, so the stream leaves it exactly one slot time after it arrived.

Top module: `ring_slot_node`

## Requirements
- R1: Every bit sampled on ser_i leaves on ser_o exactly 48 clocks later, unless the node replaces the slot that bit belongs to, and a pulse on sof_i leaves on sof_o with the same 48-clock delay.
- R2: A sof_i pulse marks bit 0 of slot 0. Slots are 48 bits, MSB first, and there are 8 of them per frame. A new sof_i pulse restarts slot and bit counting even in the middle of a frame, and bits that follow the last slot are passed through.
- R3: A node with no slot and a non-zero address replaces the first all-zero slot of a frame with its claim word: the address in slot bits [38:32] (the low part of the header) and zeros in every other bit.
- R4: A slot that holds any non-zero bit is passed through unchanged while the node scans, and the node goes on to claim a later all-zero slot.
- R5: A node claims at most one slot. Empty slots after its own slot, in the same frame and in later frames, pass through as zeros.
- R6: If a frame contains no all-zero slot, the node passes the whole frame through unchanged and claims in a later frame, the last slot included.
- R7: In frames after the claim, the node puts the incoming contents of its slot on rx_word_o and raises rx_valid_o for one clock, in the clock that follows the sampling of the slot's last bit. The slot on ser_o then carries the transmit word. No rx_valid_o pulse is raised in the frame in which the slot is claimed.
- R8: tx_word_i is sampled together with the first bit of the owned slot. A change to tx_word_i later in that slot does not alter the word that is sent.
- R9: A node whose address is zero never claims a slot, passes all data through, and never raises rx_valid_o.
- R10: Reset clears ser_o, sof_o and rx_valid_o and removes any claim. After reset the node runs discovery again and claims the first empty slot of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| node_addr_i | input | 7 | Node address written into the claimed slot; zero disables claiming |
| ser_i | input | 1 | Serial frame data in |
| sof_i | input | 1 | Frame-start strobe, high with bit 0 of slot 0 |
| tx_word_i | input | 48 | Word sent in the owned slot |
| ser_o | output | 1 | Serial frame data out, one slot time later |
| sof_o | output | 1 | Frame-start strobe passed downstream |
| rx_word_o | output | 48 | Incoming contents of the owned slot |
| rx_valid_o | output | 1 | One-clock pulse when rx_word_o is updated |

## Verification
Frames are built from non-zero slots with zero gaps in chosen positions. These show whether the scan skips occupied slots, stops after its first claim and leaves later gaps alone. A frame with no gap is followed by one whose only gap is the last slot, which separates a node that retries in the next frame from one that gives up or miscounts slots. A frame cut short by a second start strobe shows whether counting restarts. A transmit word changed mid-slot shows whether the word is sampled at the start of the slot. Address zero, and a reset after a claim, show whether claiming is properly gated and whether the claim is cleared.

// File: rtl/ring_slot_pkg.sv
package ring_slot_pkg;

  typedef enum logic [1:0] {
    SLOT_PASS  = 2'd0,
    SLOT_CLAIM = 2'd1,
    SLOT_SWAP  = 2'd2
  } slot_op_e;

endpackage

// File: rtl/ring_slot_timer.sv
module ring_slot_timer #(
  parameter int SLOT_W    = 48,
  parameter int NUM_SLOTS = 8,
  parameter int SIDX_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sof_i,
  output logic              first_o,
  output logic              last_o,
  output logic [SIDX_W-1:0] slot_idx_o
);

  localparam int BIT_W = (SLOT_W > 1) ? $clog2(SLOT_W) : 1;

  logic              act_q;
  logic [BIT_W-1:0]  bit_q;
  logic [SIDX_W-1:0] slot_q;

  logic              cur_act;
  logic [BIT_W-1:0]  cur_bit;
  logic [SIDX_W-1:0] cur_slot;
  logic              cur_last;

  // a start strobe overrides whatever position the counters hold
  always_comb begin
    cur_act  = sof_i | act_q;
    cur_bit  = sof_i ? '0 : bit_q;
    cur_slot = sof_i ? '0 : slot_q;
    cur_last = cur_act && (cur_bit == BIT_W'(SLOT_W - 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      bit_q  <= '0;
      slot_q <= '0;
    end else if (cur_act) begin
      if (cur_last) begin
        bit_q <= '0;
        if (cur_slot == SIDX_W'(NUM_SLOTS - 1)) begin
          act_q  <= 1'b0;
          slot_q <= '0;
        end else begin
          act_q  <= 1'b1;
          slot_q <= cur_slot + 1'b1;
        end
      end else begin
        act_q  <= 1'b1;
        bit_q  <= cur_bit + 1'b1;
        slot_q <= cur_slot;
      end
    end
  end

  assign first_o    = cur_act && (cur_bit == '0);
  assign last_o     = cur_last;
  assign slot_idx_o = cur_slot;

endmodule

// File: rtl/ring_slot_delay.sv
module ring_slot_delay #(
  parameter int SLOT_W = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_i,
  input  logic              sof_i,
  input  logic              load_i,
  input  logic [SLOT_W-1:0] load_word_i,
  output logic [SLOT_W-1:0] slot_word_o,
  output logic              ser_o,
  output logic              sof_o
);

  logic [SLOT_W-1:0] line_q;
  logic [SLOT_W-1:0] flag_q;

  // the slot as it stands once the current bit is taken in
  assign slot_word_o = {line_q[SLOT_W-2:0], ser_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      flag_q <= '0;
      ser_o  <= 1'b0;
      sof_o  <= 1'b0;
    end else begin
      line_q <= load_i ? load_word_i : slot_word_o;
      flag_q <= {flag_q[SLOT_W-2:0], sof_i};
      ser_o  <= line_q[SLOT_W-1];
      sof_o  <= flag_q[SLOT_W-1];
    end
  end

endmodule

// File: rtl/ring_slot_ctrl.sv
module ring_slot_ctrl
  import ring_slot_pkg::*;
#(
  parameter int SLOT_W = 48,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7,
  parameter int SIDX_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              first_i,
  input  logic              last_i,
  input  logic [SIDX_W-1:0] slot_idx_i,
  input  logic [SLOT_W-1:0] slot_word_i,
  input  logic [SLOT_W-1:0] tx_word_i,
  input  logic [ADDR_W-1:0] node_addr_i,
  output logic              load_o,
  output logic [SLOT_W-1:0] load_word_o,
  output logic [SLOT_W-1:0] rx_word_o,
  output logic              rx_valid_o,
  output logic              owned_o,
  output logic [SIDX_W-1:0] own_slot_o
);

  logic              owned_q;
  logic [SIDX_W-1:0] own_q;
  logic [SLOT_W-1:0] hold_q;
  logic              hit;
  logic [SLOT_W-1:0] claim_w;
  slot_op_e          op;

  assign hit = owned_q && (slot_idx_i == own_q);

  always_comb begin
    claim_w = '0;
    claim_w[DATA_W +: ADDR_W] = node_addr_i;
  end

  always_comb begin
    op = SLOT_PASS;
    if (last_i) begin
      if (hit)
        op = SLOT_SWAP;
      else if (!owned_q && (slot_word_i == '0) && (node_addr_i != '0))
        op = SLOT_CLAIM;
    end
  end

  assign load_o      = (op != SLOT_PASS);
  assign load_word_o = (op == SLOT_SWAP) ? hold_q : claim_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owned_q    <= 1'b0;
      own_q      <= '0;
      hold_q     <= '0;
      rx_word_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= (op == SLOT_SWAP);
      if (first_i && hit)
        hold_q <= tx_word_i;
      if (op == SLOT_SWAP)
        rx_word_o <= slot_word_i;
      if (op == SLOT_CLAIM) begin
        owned_q <= 1'b1;
        own_q   <= slot_idx_i;
      end
    end
  end

  assign owned_o    = owned_q;
  assign own_slot_o = own_q;

endmodule

// File: rtl/ring_slot_node.sv
module ring_slot_node #(
  parameter int HDR_W     = 16,
  parameter int DATA_W    = 32,
  parameter int NUM_SLOTS = 8,
  parameter int ADDR_W    = 7,
  localparam int SLOT_W   = HDR_W + DATA_W,
  localparam int SIDX_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] node_addr_i,
  input  logic              ser_i,
  input  logic              sof_i,
  input  logic [SLOT_W-1:0] tx_word_i,
  output logic              ser_o,
  output logic              sof_o,
  output logic [SLOT_W-1:0] rx_word_o,
  output logic              rx_valid_o
);

  logic              first_w;
  logic              last_w;
  logic [SIDX_W-1:0] slot_idx_w;
  logic [SLOT_W-1:0] slot_word_w;
  logic              load_w;
  logic [SLOT_W-1:0] load_word_w;
  logic              owned_w;
  logic [SIDX_W-1:0] own_slot_w;

  ring_slot_timer #(
    .SLOT_W   (SLOT_W),
    .NUM_SLOTS(NUM_SLOTS),
    .SIDX_W   (SIDX_W)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sof_i     (sof_i),
    .first_o   (first_w),
    .last_o    (last_w),
    .slot_idx_o(slot_idx_w)
  );

  ring_slot_delay #(
    .SLOT_W(SLOT_W)
  ) u_delay (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ser_i      (ser_i),
    .sof_i      (sof_i),
    .load_i     (load_w),
    .load_word_i(load_word_w),
    .slot_word_o(slot_word_w),
    .ser_o      (ser_o),
    .sof_o      (sof_o)
  );

  ring_slot_ctrl #(
    .SLOT_W(SLOT_W),
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .SIDX_W(SIDX_W)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .first_i    (first_w),
    .last_i     (last_w),
    .slot_idx_i (slot_idx_w),
    .slot_word_i(slot_word_w),
    .tx_word_i  (tx_word_i),
    .node_addr_i(node_addr_i),
    .load_o     (load_w),
    .load_word_o(load_word_w),
    .rx_word_o  (rx_word_o),
    .rx_valid_o (rx_valid_o),
    .owned_o    (owned_w),
    .own_slot_o (own_slot_w)
  );

endmodule

// File: rtl/ring_slot_node_chk.sv
module ring_slot_node_chk #(
  parameter int ADDR_W = 7,
  parameter int SIDX_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] node_addr_i,
  input logic              rx_valid_o,
  input logic              owned,
  input logic [SIDX_W-1:0] own_slot,
  input logic              load,
  input logic              last
);

  assert_rx_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  assert_rx_needs_slot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> owned);

  assert_claim_kept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owned |=> owned && $stable(own_slot));

  assert_claim_addr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(owned) |-> $past(node_addr_i) != '0);

  assert_load_at_slot_end_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |-> last);

endmodule

bind ring_slot_node ring_slot_node_chk #(
  .ADDR_W(ADDR_W),
  .SIDX_W(SIDX_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .node_addr_i(node_addr_i),
  .rx_valid_o (rx_valid_o),
  .owned      (owned_w),
  .own_slot   (own_slot_w),
  .load       (load_w),
  .last       (last_w)
);

// File: tb/ring_slot_node_test.sv
module ring_slot_node_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int SW = 48;
  localparam int NS = 8;
  localparam int FB = SW * NS;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [6:0]    node_addr = 7'd0;
  logic          ser_i = 1'b0;
  logic          sof_i = 1'b0;
  logic [SW-1:0] tx_word = '0;
  logic          ser_o, sof_o, rx_valid_o;
  logic [SW-1:0] rx_word_o;

  always #5 clk = ~clk;

  ring_slot_node uut (
    .clk_i(clk), .rst_ni(rst_ni), .node_addr_i(node_addr),
    .ser_i(ser_i), .sof_i(sof_i), .tx_word_i(tx_word),
    .ser_o(ser_o), .sof_o(sof_o), .rx_word_o(rx_word_o), .rx_valid_o(rx_valid_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  logic          q_ser[$];
  logic          q_sof[$];
  bit            m_owned;
  int            m_own, m_bit, m_slot;
  bit            m_act;
  logic [SW-1:0] m_hold, m_w;
  bit            rx_pend;
  logic [SW-1:0] rx_exp;

  // observation
  logic [SW-1:0] cap [NS];
  int            cap_pos;
  int            rx_cnt;
  logic [SW-1:0] rx_last;
  logic [SW-1:0] fin [NS];
  bit            chg_on;
  int            chg_slot, chg_bit;
  logic [SW-1:0] tx_alt;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [SW-1:0] act, input logic [SW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] claim_of(input logic [6:0] a);
    logic [SW-1:0] w = '0;
    w[32 +: 7] = a;
    return w;
  endfunction

  task automatic overwrite(input logic [SW-1:0] w);
    for (int i = 0; i < SW; i++) q_ser[q_ser.size() - SW + i] = w[SW-1-i];
  endtask

  task automatic do_step(input logic b, input logic s);
    logic e_ser, e_sof;
    e_ser = q_ser.pop_front();
    e_sof = q_sof.pop_front();
    check(ser_o === e_ser, "R1", "ser_o", {47'd0, ser_o}, {47'd0, e_ser});
    check(sof_o === e_sof, "R2", "sof_o", {47'd0, sof_o}, {47'd0, e_sof});
    check(rx_valid_o === rx_pend, "R7", "rx_valid_o", {47'd0, rx_valid_o}, {47'd0, rx_pend});
    if (rx_pend) check(rx_word_o === rx_exp, "R7", "rx_word_o", rx_word_o, rx_exp);
    if (rx_valid_o === 1'b1) begin rx_cnt++; rx_last = rx_word_o; end
    rx_pend = 0;
    if (sof_o === 1'b1) cap_pos = 0;
    if (cap_pos >= 0 && cap_pos < FB) begin
      cap[cap_pos / SW][SW - 1 - (cap_pos % SW)] = ser_o;
      cap_pos++;
    end
    ser_i = b;
    sof_i = s;
    q_ser.push_back(b);
    q_sof.push_back(s);
    if (s) begin m_act = 1; m_bit = 0; m_slot = 0; end
    if (m_act) begin
      if (m_bit == 0 && m_owned && m_slot == m_own) m_hold = tx_word;
      m_w = {m_w[SW-2:0], b};
      if (m_bit == SW - 1) begin
        if (m_owned && m_slot == m_own) begin
          rx_pend = 1; rx_exp = m_w; overwrite(m_hold);
        end else if (!m_owned && m_w == '0 && node_addr != 7'd0) begin
          overwrite(claim_of(node_addr)); m_owned = 1; m_own = m_slot;
        end
        m_bit = 0;
        if (m_slot == NS - 1) m_act = 0; else m_slot++;
      end else m_bit++;
    end
  endtask

  task automatic step(input logic b, input logic s);
    @(negedge clk);
    do_step(b, s);
  endtask

  task automatic do_reset(input logic [6:0] a);
    @(negedge clk);
    rst_ni = 1'b0; ser_i = 1'b0; sof_i = 1'b0; node_addr = a;
    repeat (3) @(negedge clk);
    check(ser_o === 1'b0 && sof_o === 1'b0 && rx_valid_o === 1'b0, "R10", "reset outputs",
          {45'd0, ser_o, sof_o, rx_valid_o}, '0);
    q_ser.delete(); q_sof.delete();
    for (int i = 0; i < SW + 1; i++) begin q_ser.push_back(1'b0); q_sof.push_back(1'b0); end
    m_owned = 0; m_own = 0; m_act = 0; m_bit = 0; m_slot = 0; m_hold = '0; m_w = '0;
    rx_pend = 0; cap_pos = -1;
    rst_ni = 1'b1;
    do_step(1'b0, 1'b0);
  endtask

  task automatic run_frame();
    cap_pos = -1; rx_cnt = 0;
    for (int s = 0; s < NS; s++)
      for (int b = 0; b < SW; b++) begin
        @(negedge clk);
        if (chg_on && s == chg_slot && b == chg_bit) tx_word = tx_alt;
        do_step(fin[s][SW-1-b], (s == 0 && b == 0));
      end
  endtask

  task automatic flush(input int n, input logic v);
    for (int i = 0; i < n; i++) step(v, 1'b0);
  endtask

  task automatic fill_busy();
    for (int i = 0; i < NS; i++) fin[i] = 48'hA5C3_0000_0000 + SW'(i * 17 + 1);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit same;
    chg_on = 0; tx_alt = '0;
    // scan skips busy slots, claims slot 2, leaves slot 5 alone
    do_reset(7'd5);
    fill_busy(); fin[2] = '0; fin[5] = '0;
    run_frame(); flush(60, 1'b0);
    check(cap[2] === claim_of(7'd5), "R3", "claim word", cap[2], claim_of(7'd5));
    check(cap[0] === fin[0], "R4", "busy slot 0", cap[0], fin[0]);
    check(cap[3] === fin[3], "R4", "busy slot 3", cap[3], fin[3]);
    check(cap[5] === '0, "R5", "later gap", cap[5], '0);
    check(rx_cnt == 0, "R7", "no rx in claim frame", SW'(rx_cnt), '0);

    // owned slot: swap, rx capture, tx changed mid-slot
    tx_word = 48'h1234_5678_9ABC; tx_alt = 48'hDEAD_BEEF_0F0F;
    chg_on = 1; chg_slot = 2; chg_bit = 10;
    fill_busy(); fin[2] = 48'hFFFF_0000_1111; fin[5] = '0;
    run_frame(); flush(60, 1'b0);
    chg_on = 0;
    check(cap[2] === 48'h1234_5678_9ABC, "R8", "sent word", cap[2], 48'h1234_5678_9ABC);
    check(rx_cnt == 1, "R7", "rx pulse count", SW'(rx_cnt), 48'd1);
    check(rx_last === fin[2], "R7", "rx word", rx_last, fin[2]);
    check(cap[5] === '0, "R5", "gap after claim", cap[5], '0);

    // reset clears the claim
    do_reset(7'd5);
    for (int i = 0; i < NS; i++) fin[i] = '0;
    run_frame(); flush(60, 1'b0);
    check(cap[0] === claim_of(7'd5), "R10", "reclaim slot 0", cap[0], claim_of(7'd5));
    check(cap[2] === '0, "R10", "old slot free", cap[2], '0);

    // full frame, then only the last slot empty, then trailing bits
    do_reset(7'd9);
    fill_busy();
    run_frame(); flush(60, 1'b0);
    same = 1;
    for (int i = 0; i < NS; i++) if (cap[i] !== fin[i]) same = 0;
    check(same, "R6", "full frame untouched", {47'd0, same}, 48'd1);
    fin[NS-1] = '0;
    run_frame(); flush(30, 1'b1); flush(60, 1'b0);
    check(cap[NS-1] === claim_of(7'd9), "R6", "claim last slot", cap[NS-1], claim_of(7'd9));

    // restart mid-frame
    do_reset(7'd3);
    fill_busy();
    for (int i = 0; i < 100; i++) step(fin[i / SW][SW - 1 - (i % SW)], i == 0);
    fin[0] = '0;
    run_frame(); flush(60, 1'b0);
    check(cap[0] === claim_of(7'd3), "R2", "restart claim", cap[0], claim_of(7'd3));

    // address zero never claims
    do_reset(7'd0);
    for (int i = 0; i < NS; i++) fin[i] = '0;
    run_frame(); flush(60, 1'b0);
    same = 1;
    for (int i = 0; i < NS; i++) if (cap[i] !== '0) same = 0;
    check(same, "R9", "zero address passes", {47'd0, same}, 48'd1);
    run_frame(); flush(60, 1'b0);
    check(rx_cnt == 0, "R9", "no rx", SW'(rx_cnt), '0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule